// File: doc/BRIEF.md
# Primary Clock Failure Monitor with Automatic Switchover

This block supervises an external primary clock from the point of view of a free-running internal oscillator. A slow reference, the sample clock, is derived by dividing the internal clock by a parameter (64 by default). Every primary falling edge sets a monitor bit, and the start of each sample high phase clears it. If the bit is still clear when the sample phase ends, the primary clock is declared failed.

On failure the block sets a sticky failure flag and drives an interrupt when the interrupt is enabled. It also drops the "primary running" status bit, pulses a watchdog-clear output for one cycle, and moves the system clock onto the internal oscillator. Once primary falling edges are seen again in consecutive sample windows, the status bit returns and the system clock goes back to the primary source. The failure flag stays set until software clears it.

Monitoring only runs while it is enabled and the oscillator start-up interval has been reported complete. The clock multiplexer is a plain registered select; it is not glitch-free.

Top module: `clkmon_top`

## Requirements
- R1: The sample window is the first DIV/2 internal cycles of each DIV-cycle sample period. If no primary falling edge arrives in that window, `fail_flag` rises at the end of the window. A stopped primary clock is flagged within 2*DIV internal cycles plus synchronizer latency.
- R2: While `en` is 0 or `ost_done` is 0, no failure is ever flagged, whatever the primary clock does.
- R3: A primary clock whose period is shorter than the window (DIV/2 internal cycles) is never flagged. While it is monitored, `sys_sel` stays 0 and `clk_ok` stays 1.
- R4: `fail_flag` is sticky: once set, it stays 1 until a `fail_clr` pulse, which drops it on the next cycle.
- R5: `irq` is 1 exactly when `fail_flag` is 1 and `irq_en` is 1.
- R6: On failure entry, `sys_sel` goes to 1 and `clk_ok` to 0 on the same cycle that `fail_flag` rises. `sys_clk` then follows `int_clk`; with `sys_sel` at 0 it follows `pri_clk`.
- R7: `wdt_clr` is high for exactly one internal cycle at each failure entry and never at any other time.
- R8: After the primary clock restarts, the failed condition is left after REC consecutive sample windows (default 2) that each contain a primary falling edge. `sys_sel` returns to 0, `clk_ok` returns to 1, and `fail_flag` stays set.
- R9: A running primary clock that is too slow to put a falling edge in every window is treated as failed.
- R10: After reset, `fail_flag`, `irq`, `wdt_clr`, `sys_sel` and `clk_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Free-running internal oscillator clock |
| pri_clk | input | 1 | External primary clock being monitored |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Monitor enable |
| ost_done | input | 1 | Primary start-up interval has expired |
| irq_en | input | 1 | Failure interrupt enable |
| fail_clr | input | 1 | Software clear of the sticky failure flag |
| sys_clk | output | 1 | Selected system clock |
| fail_flag | output | 1 | Sticky failure flag |
| irq | output | 1 | Failure interrupt |
| clk_ok | output | 1 | Primary clock is running and selected |
| wdt_clr | output | 1 | One-cycle watchdog clear at failure entry |
| sys_sel | output | 1 | System clock source: 0 primary, 1 internal |

## Verification
The bench keeps the default divider of 64 and recovery count of 2. This makes a whole sample period only 512 ns at the 125 MHz internal clock, so detection and recovery latencies can be measured in internal cycles against bounds derived from DIV. The primary half-period is swept across values well inside the window and one well outside it. Stop, restart, enable gating and flag clearing are each exercised, and the selected system clock is checked by counting its edges against both sources.

// File: rtl/clkmon_pkg.sv
// Shared types for the clock failure monitor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package clkmon_pkg;

    // Monitor condition: primary in use, or fallen back to internal.
    typedef enum logic {
        MON_RUN    = 1'b0,
        MON_FAILED = 1'b1
    } mon_state_t;

endpackage

// File: rtl/clkmon_sample_gen.sv
// Divides the internal clock into a sample period of DIV cycles.
// It gives one-cycle markers at the start of the high phase (win_open)
// and at its end (win_close). Assumes DIV is even and at least 4.
module clkmon_sample_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_open,
    output logic win_close
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] div_q;

    // Free-running divider counter, wrapping at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == CW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign win_open  = (div_q == '0);
    assign win_close = (div_q == CW'(HALF));
endmodule

// File: rtl/clkmon_edge_sync.sv
// Turns each primary falling edge into a one-cycle pulse on the internal clock.
// A toggle flop in the primary domain feeds a SYNC-stage synchronizer.
// Assumes the primary clock toggles well below half the internal rate.
module clkmon_edge_sync #(
    parameter int SYNC = 2
) (
    input  logic pri_clk,
    input  logic int_clk,
    input  logic rst_n,
    output logic edge_seen
);
    logic          tog_q;
    logic [SYNC:0] chain_q;

    // Flip the toggle on every primary falling edge.
    always_ff @(negedge pri_clk) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else
            tog_q <= ~tog_q;
    end

    // Synchronizer stages plus one history stage for change detection.
    always_ff @(posedge int_clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[SYNC-1:0], tog_q};
    end

    assign edge_seen = chain_q[SYNC] ^ chain_q[SYNC-1];
endmodule

// File: rtl/clkmon_monitor.sv
// Failure detector and switchover control in the internal clock domain.
// Holds the monitor bit, the run/failed state, the recovery count, the
// sticky flag, the status bit and the watchdog-clear pulse.
// Assumes window markers and edge pulses are single-cycle and synchronous.
module clkmon_monitor
    import clkmon_pkg::*;
#(
    parameter int REC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ost_done,
    input  logic win_open,
    input  logic win_close,
    input  logic edge_seen,
    input  logic fail_clr,
    output logic fail_flag,
    output logic wdt_clr,
    output logic sys_sel,
    output logic clk_ok
);
    localparam int RW = $clog2(REC + 1);

    mon_state_t    state_q, state_d;
    logic [RW-1:0] rec_q, rec_d;
    logic          seen_q;
    logic          fail_evt;

    // Monitor bit: set by a primary edge, cleared when the window opens.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (edge_seen)
            seen_q <= 1'b1;
        else if (win_open)
            seen_q <= 1'b0;
    end

    assign fail_evt = win_close && active && !seen_q && (state_q == MON_RUN);

    // Next state and recovery count.
    always_comb begin
        state_d = state_q;
        rec_d   = rec_q;
        if (state_q == MON_RUN) begin
            rec_d = '0;
            if (fail_evt)
                state_d = MON_FAILED;
        end else if (!active) begin
            state_d = MON_RUN;
            rec_d   = '0;
        end else if (win_close) begin
            if (!seen_q)
                rec_d = '0;
            else if (rec_q == RW'(REC - 1)) begin
                state_d = MON_RUN;
                rec_d   = '0;
            end else
                rec_d = rec_q + 1'b1;
        end
    end

    // State, count, flag, pulse and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MON_RUN;
            rec_q     <= '0;
            fail_flag <= 1'b0;
            wdt_clr   <= 1'b0;
            clk_ok    <= 1'b0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
            wdt_clr <= fail_evt;
            clk_ok  <= (state_d == MON_RUN) && ost_done;
            if (fail_evt)
                fail_flag <= 1'b1;
            else if (fail_clr)
                fail_flag <= 1'b0;
        end
    end

    assign sys_sel = (state_q == MON_FAILED);
endmodule

// File: rtl/clkmon_top.sv
// Top of the primary clock failure monitor.
// Wires the divider, the edge synchronizer and the monitor together, and
// selects the system clock with a plain (not glitch-free) registered select.
module clkmon_top #(
    parameter int DIV  = 64,
    parameter int SYNC = 2,
    parameter int REC  = 2
) (
    input  logic int_clk,
    input  logic pri_clk,
    input  logic rst_n,
    input  logic en,
    input  logic ost_done,
    input  logic irq_en,
    input  logic fail_clr,
    output logic sys_clk,
    output logic fail_flag,
    output logic irq,
    output logic clk_ok,
    output logic wdt_clr,
    output logic sys_sel
);
    logic win_open, win_close, edge_seen;

    clkmon_sample_gen #(.DIV(DIV)) i_div (
        .clk       (int_clk),
        .rst_n     (rst_n),
        .win_open  (win_open),
        .win_close (win_close)
    );

    clkmon_edge_sync #(.SYNC(SYNC)) i_sync (
        .pri_clk   (pri_clk),
        .int_clk   (int_clk),
        .rst_n     (rst_n),
        .edge_seen (edge_seen)
    );

    clkmon_monitor #(.REC(REC)) i_mon (
        .clk       (int_clk),
        .rst_n     (rst_n),
        .active    (en && ost_done),
        .ost_done  (ost_done),
        .win_open  (win_open),
        .win_close (win_close),
        .edge_seen (edge_seen),
        .fail_clr  (fail_clr),
        .fail_flag (fail_flag),
        .wdt_clr   (wdt_clr),
        .sys_sel   (sys_sel),
        .clk_ok    (clk_ok)
    );

    assign irq     = fail_flag && irq_en;
    assign sys_clk = sys_sel ? int_clk : pri_clk;
endmodule

// File: rtl/clkmon_checker.sv
// Temporal properties of the clock failure monitor, bound to clkmon_top.
module clkmon_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ost_done,
    input logic fail_clr,
    input logic fail_flag,
    input logic wdt_clr,
    input logic sys_sel,
    input logic clk_ok
);
    a_r2_no_fail_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !ost_done) |=> !$rose(fail_flag));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !fail_clr) |=> fail_flag);

    a_r6_flag_with_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_sel) |-> $rose(fail_flag) || $past(fail_flag));

    a_r6_status_low: assert property (@(posedge clk) disable iff (!rst_n)
        sys_sel |-> !clk_ok);

    a_r7_wdt_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    a_r7_wdt_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_sel) |-> wdt_clr);
endmodule

bind clkmon_top clkmon_checker i_chk (
    .clk       (int_clk),
    .rst_n     (rst_n),
    .en        (en),
    .ost_done  (ost_done),
    .fail_clr  (fail_clr),
    .fail_flag (fail_flag),
    .wdt_clr   (wdt_clr),
    .sys_sel   (sys_sel),
    .clk_ok    (clk_ok)
);

// File: tb/test_clkmon_top.sv
`timescale 1ns/1ps
module test_clkmon_top;
    localparam int DIV = 64;

    logic int_clk = 1'b0;
    logic pri_clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ost_done = 1'b0, irq_en = 1'b0, fail_clr = 1'b0;
    logic sys_clk, fail_flag, irq, clk_ok, wdt_clr, sys_sel;

    int  pri_half = 20;
    bit  pri_run  = 1'b1;
    int  checks = 0, errors = 0;
    int  wdt_cnt = 0, sys_rises = 0;
    bit  done = 1'b0;

    clkmon_top #(.DIV(DIV)) i_clkmon_top (
        .int_clk(int_clk), .pri_clk(pri_clk), .rst_n(rst_n), .en(en),
        .ost_done(ost_done), .irq_en(irq_en), .fail_clr(fail_clr),
        .sys_clk(sys_clk), .fail_flag(fail_flag), .irq(irq),
        .clk_ok(clk_ok), .wdt_clr(wdt_clr), .sys_sel(sys_sel)
    );

    always #4 int_clk = ~int_clk;

    always begin
        if (pri_run) #(pri_half) pri_clk = ~pri_clk;
        else #4;
    end

    always @(negedge int_clk) if (wdt_clr) wdt_cnt++;
    always @(posedge sys_clk) sys_rises++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge int_clk);
    endtask

    // Cycles until sig matches val, or limit+1 if it never does.
    task automatic wait_for(input bit want_flag, input bit val, input int limit, output int n);
        n = 0;
        while (n <= limit && ((want_flag ? fail_flag : sys_sel) != val)) begin
            @(negedge int_clk);
            n++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        int n, w0, r0;
        cyc(10);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        chk("R10 fail_flag", fail_flag, 0);
        chk("R10 irq", irq, 0);
        chk("R10 wdt_clr", wdt_clr, 0);
        chk("R10 sys_sel", sys_sel, 0);
        chk("R10 clk_ok", clk_ok, 0);

        // R2 disabled or start-up not done: stopped primary ignored
        pri_run = 1'b0; en = 1'b0; ost_done = 1'b1;
        cyc(4 * DIV);
        chk("R2 en=0 flag", fail_flag, 0);
        chk("R2 en=0 sel", sys_sel, 0);
        en = 1'b1; ost_done = 1'b0;
        cyc(4 * DIV);
        chk("R2 ost=0 flag", fail_flag, 0);
        chk("R2 ost=0 sel", sys_sel, 0);
        pri_run = 1'b1;
        cyc(2 * DIV);
        ost_done = 1'b1;

        // R3 sweep of running primary periods shorter than the window
        for (int h = 12; h <= 100; h += 22) begin
            pri_half = h;
            cyc(6 * DIV);
            chk($sformatf("R3 half=%0d flag", h), fail_flag, 0);
            chk($sformatf("R3 half=%0d sel", h), sys_sel, 0);
            chk($sformatf("R3 half=%0d ok", h), clk_ok, 1);
        end

        // R6 sys_clk follows primary: half 20 ns gives one rise per 5 cycles
        pri_half = 20;
        cyc(DIV);
        r0 = sys_rises;
        cyc(400);
        chk_rng("R6 sys_clk on primary", sys_rises - r0, 79, 81);

        // R1 stop primary: flagged within two periods plus latency
        w0 = wdt_cnt;
        pri_run = 1'b0;
        wait_for(1'b1, 1'b1, 2 * DIV + 8, n);
        chk_rng("R1 detect latency", n, 1, 2 * DIV + 8);
        chk("R6 sel at entry", sys_sel, 1);
        chk("R6 clk_ok at entry", clk_ok, 0);
        chk("R5 irq with irq_en=0", irq, 0);
        cyc(3 * DIV);
        chk("R7 wdt pulses", wdt_cnt - w0, 1);
        chk("R4 flag held", fail_flag, 1);
        irq_en = 1'b1;
        cyc(1);
        chk("R5 irq with irq_en=1", irq, 1);
        r0 = sys_rises;
        cyc(20);
        chk("R6 sys_clk on internal", sys_rises - r0, 20);

        // R8 restart primary: recovery after two good windows, flag kept
        pri_run = 1'b1;
        wait_for(1'b0, 1'b0, 3 * DIV + 8, n);
        chk_rng("R8 recovery latency", n, DIV - 4, 3 * DIV + 8);
        cyc(1);
        chk("R8 clk_ok restored", clk_ok, 1);
        chk("R8 flag kept", fail_flag, 1);
        chk("R7 no wdt on exit", wdt_cnt - w0, 1);

        // R4 software clear
        fail_clr = 1'b1;
        cyc(1);
        fail_clr = 1'b0;
        cyc(1);
        chk("R4 flag cleared", fail_flag, 0);
        chk("R5 irq cleared", irq, 0);

        // R9 primary running but far too slow
        pri_half = 600;
        wait_for(1'b1, 1'b1, 8 * DIV, n);
        chk("R9 slow primary flagged", fail_flag, 1);
        chk("R9 slow primary switched", sys_sel, 1);

        finish_run();
    end
endmodule